// File: doc/BRIEF.md
# Byte-Aliased Dual-Read Register File

This block is the general-purpose register store of a small 16-bit processor core. It holds eight word registers. One write port and two independent read ports serve it, and one width flag decides whether the current cycle works on whole words or on single bytes. Each read port returns a registered result. The value appears on the clock edge after the select is presented. A write that lands on that same edge is forwarded, so a read placed right behind a write already sees the new contents.

In byte mode the eight select codes do not reach all eight registers. Codes 0 to 3 name the low byte of word registers 0 to 3, and codes 4 to 7 name the high byte of those same four registers. Byte writes touch only the named half. Byte reads return the named half in the low eight bits, with the upper eight bits zero.

Top module: `byte_alias_regfile`

## Requirements
- R1: With the width flag low, a write of a 16-bit value to select s (0 to 7) stores it whole, and a later word read of s returns it unchanged.
- R2: When wrEn is low at a rising edge, no register changes, whatever wrSel, wrData and the width flag hold.
- R3: The two read ports are independent. In one cycle they can return two different registers, and two equal selects return equal data.
- R4: With the width flag high, read select s in 0 to 3 returns bits 7:0 of register s in bits 7:0 of the output, with bits 15:8 zero.
- R5: With the width flag high, read select s in 4 to 7 returns bits 15:8 of register s-4 in bits 7:0 of the output, with bits 15:8 zero.
- R6: A byte write to select s in 0 to 3 puts wrData[7:0] into bits 7:0 of register s and leaves bits 15:8 as they were.
- R7: A byte write to select s in 4 to 7 puts wrData[7:0] into bits 15:8 of register s-4 and leaves bits 7:0 as they were.
- R8: Each read output changes only on a rising edge. It then shows the data chosen by the select and width flag sampled at that edge, and holds that data until the next edge.
- R9: When a read and a write fall on the same edge and touch the same register, the read output shows the contents after the write, with the byte merge applied.
- R10: Reset, asynchronous and active high, clears all eight registers and both read outputs to zero.
- R11: One width flag governs the write port and both read ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| byteMode | input | 1 | Width flag: 1 selects byte access, 0 selects word access |
| wrEn | input | 1 | Write enable, sampled at the rising edge |
| wrSel | input | 3 | Write register or byte select |
| wrData | input | 16 | Write value; byte writes use bits 7:0 |
| rdSelA | input | 3 | Read select, port A |
| rdSelB | input | 3 | Read select, port B |
| rdDataA | output | 16 | Registered read data, port A |
| rdDataB | output | 16 | Registered read data, port B |

## Verification
A write and a read of the same register can land on one rising edge. The read must then carry the merged result of the write rather than the old contents. The bench provokes this by driving wrEn, wrSel and a read select equal to wrSel in one cycle, in word mode and in both byte halves. Just after that edge it compares the read output with a bench model that has already applied the write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int REG_COUNT   = 8;
  localparam int WORD_W      = 16;
  localparam int SEL_W       = $clog2(REG_COUNT);
  localparam int BYTE_W      = WORD_W / 2;
  localparam int ALIAS_COUNT = REG_COUNT / 2;

  typedef enum logic [1:0] {
    LANE_WORD = 2'd0,
    LANE_LO   = 2'd1,
    LANE_HI   = 2'd2
  } lane_e;

  typedef struct packed {
    logic [REG_COUNT-1:0] loWe;
    logic [REG_COUNT-1:0] hiWe;
    logic                 hiFromLow;
  } wrStrobe_t;

  typedef struct packed {
    logic [SEL_W-1:0] idx;
    lane_e            lane;
  } rdCtl_t;

  typedef struct packed {
    wrStrobe_t wr;
    rdCtl_t    rdA;
    rdCtl_t    rdB;
  } ctlStrobes_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic             byteMode,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [SEL_W-1:0] rdSelA,
  input  logic [SEL_W-1:0] rdSelB,
  output ctlStrobes_t      strobes
);
  localparam logic [SEL_W-1:0] ALIAS_IDX = SEL_W'(ALIAS_COUNT);

  function automatic rdCtl_t decodeRead(input logic [SEL_W-1:0] sel, input logic byteM);
    rdCtl_t c;
    if (!byteM) begin
      c.idx  = sel;
      c.lane = LANE_WORD;
    end else if (sel < ALIAS_IDX) begin
      c.idx  = sel;
      c.lane = LANE_LO;
    end else begin
      c.idx  = sel - ALIAS_IDX;
      c.lane = LANE_HI;
    end
    return c;
  endfunction

  logic [SEL_W-1:0] wrIdx;
  logic             wrUpper;

  always_comb begin
    wrUpper = byteMode && (wrSel >= ALIAS_IDX);
    wrIdx   = wrUpper ? (wrSel - ALIAS_IDX) : wrSel;
  end

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : gen_we
      always_comb begin
        strobes.wr.loWe[g] = wrEn && (wrIdx == SEL_W'(g)) && !wrUpper;
        strobes.wr.hiWe[g] = wrEn && (wrIdx == SEL_W'(g)) && (wrUpper || !byteMode);
      end
    end
  endgenerate

  always_comb begin
    strobes.wr.hiFromLow = byteMode;
    strobes.rdA          = decodeRead(rdSelA, byteMode);
    strobes.rdB          = decodeRead(rdSelB, byteMode);
  end
endmodule

// File: rtl/regfile_rdport.sv
module regfile_rdport
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] regIn [REG_COUNT],
  input  rdCtl_t            ctl,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] shaped;

  always_comb begin
    picked = regIn[ctl.idx];
    unique case (ctl.lane)
      LANE_LO: shaped = {{BYTE_W{1'b0}}, picked[BYTE_W-1:0]};
      LANE_HI: shaped = {{BYTE_W{1'b0}}, picked[WORD_W-1:BYTE_W]};
      default: shaped = picked;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rdData <= '0;
    else     rdData <= shaped;
  end
endmodule

// File: rtl/regfile_datapath.sv
module regfile_datapath
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB
);
  logic [WORD_W-1:0] regQ    [REG_COUNT];
  logic [WORD_W-1:0] regNext [REG_COUNT];
  logic [BYTE_W-1:0] hiSrc;

  assign hiSrc = strobes.wr.hiFromLow ? wrData[BYTE_W-1:0] : wrData[WORD_W-1:BYTE_W];

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : gen_reg
      assign regNext[g][BYTE_W-1:0] =
        strobes.wr.loWe[g] ? wrData[BYTE_W-1:0] : regQ[g][BYTE_W-1:0];
      assign regNext[g][WORD_W-1:BYTE_W] =
        strobes.wr.hiWe[g] ? hiSrc : regQ[g][WORD_W-1:BYTE_W];

      always_ff @(posedge clk or posedge rst) begin
        if (rst) regQ[g] <= '0;
        else     regQ[g] <= regNext[g];
      end
    end
  endgenerate

  regfile_rdport u_portA (
    .clk    (clk),
    .rst    (rst),
    .regIn  (regNext),
    .ctl    (strobes.rdA),
    .rdData (rdDataA)
  );

  regfile_rdport u_portB (
    .clk    (clk),
    .rst    (rst),
    .regIn  (regNext),
    .ctl    (strobes.rdB),
    .rdData (rdDataB)
  );
endmodule

// File: rtl/byte_alias_regfile.sv
module byte_alias_regfile
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byteMode,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB
);
  ctlStrobes_t strobes;

  regfile_ctrl u_ctrl (
    .byteMode (byteMode),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .rdSelA   (rdSelA),
    .rdSelB   (rdSelB),
    .strobes  (strobes)
  );

  regfile_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk
  import regfile_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              byteMode,
  input logic              wrEn,
  input logic [SEL_W-1:0]  wrSel,
  input logic [WORD_W-1:0] wrData,
  input logic [SEL_W-1:0]  rdSelA,
  input logic [SEL_W-1:0]  rdSelB,
  input logic [WORD_W-1:0] rdDataA,
  input logic [WORD_W-1:0] rdDataB
);
  // R10: the edge after a reset cycle still shows cleared outputs
  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdDataA == '0 && rdDataB == '0));

  // R4 and R5: byte reads are zero-extended
  assert_byte_zero_ext_R5: assert property (@(posedge clk) disable iff (rst)
    $past(byteMode) |-> (rdDataA[WORD_W-1:BYTE_W] == '0 && rdDataB[WORD_W-1:BYTE_W] == '0));

  // R3: equal selects on both ports give equal data
  assert_equal_sel_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rdSelA == rdSelB) |-> (rdDataA == rdDataB));

  // R9: word write forwarded to a same-edge word read
  assert_word_forward_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wrEn && !byteMode && rdSelA == wrSel) |-> (rdDataA == $past(wrData)));

  // R9 and R11: byte write forwarded to a same-edge byte read on port B
  assert_byte_forward_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wrEn && byteMode && rdSelB == wrSel) |->
      (rdDataB[BYTE_W-1:0] == $past(wrData[BYTE_W-1:0])));
endmodule

bind byte_alias_regfile regfile_chk u_chk (.*);

// File: tb/byte_alias_regfile_bench.sv
`timescale 1ns/1ps
module byte_alias_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byteMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdSelA = '0;
  logic [2:0]  rdSelB = '0;
  logic [15:0] rdDataA;
  logic [15:0] rdDataB;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] model [8];

  always #2.5 clk = ~clk;

  byte_alias_regfile u_byte_alias_regfile (
    .clk(clk), .rst(rst), .byteMode(byteMode), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSelA(rdSelA), .rdSelB(rdSelB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  function automatic logic [15:0] expRead(input logic [2:0] sel, input logic bm);
    if (!bm) return model[sel];
    if (sel < 3'd4) return {8'h00, model[sel][7:0]};
    return {8'h00, model[sel - 3'd4][15:8]};
  endfunction

  task automatic modelWrite(input logic [2:0] sel, input logic [15:0] d, input logic bm);
    if (!bm) model[sel] = d;
    else if (sel < 3'd4) model[sel][7:0] = d[7:0];
    else model[sel - 3'd4][15:8] = d[7:0];
  endtask

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // one edge: drive at negedge, update model at posedge, leave outputs settled
  task automatic step(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                      input logic bm, input logic [2:0] sa, input logic [2:0] sb);
    @(negedge clk);
    wrEn = we; wrSel = ws; wrData = wd; byteMode = bm; rdSelA = sa; rdSelB = sb;
    @(posedge clk);
    if (we) modelWrite(ws, wd, bm);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk); rst = 1'b1; #1;
    check("R10 outA", rdDataA, 16'h0);
    check("R10 outB", rdDataB, 16'h0);
    for (int i = 0; i < 8; i++) model[i] = '0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i += 2) begin
      step(1'b0, 3'd0, 16'h0, 1'b0, 3'(i), 3'(i + 1));
      check("R10 reg A", rdDataA, 16'h0);
      check("R10 reg B", rdDataB, 16'h0);
    end
  endtask

  task automatic testWordWrite();
    for (int i = 0; i < 8; i++) step(1'b1, 3'(i), 16'((i << 12) | (i << 4) | 16'h0A05), 1'b0, 3'd7, 3'd7);
    idle();
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 3'd0, 16'h0, 1'b0, 3'(i), 3'(7 - i));
      check("R1 word A", rdDataA, expRead(3'(i), 1'b0));
      check("R3 word B", rdDataB, expRead(3'(7 - i), 1'b0));
    end
  endtask

  task automatic testIgnoredWrite();
    step(1'b0, 3'd2, 16'hFFFF, 1'b0, 3'd0, 3'd0);
    step(1'b0, 3'd5, 16'h1234, 1'b1, 3'd0, 3'd0);
    step(1'b0, 3'd0, 16'h0, 1'b0, 3'd2, 3'd1);
    check("R2 reg2", rdDataA, expRead(3'd2, 1'b0));
    check("R2 reg1", rdDataB, expRead(3'd1, 1'b0));
  endtask

  task automatic testByteRead();
    step(1'b1, 3'd0, 16'hC3A1, 1'b0, 3'd0, 3'd0);
    step(1'b1, 3'd3, 16'h9B7E, 1'b0, 3'd0, 3'd0);
    idle();
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'(i), 3'(i + 4));
      check("R4 low byte", rdDataA, expRead(3'(i), 1'b1));
      check("R5 high byte", rdDataB, expRead(3'(i + 4), 1'b1));
    end
  endtask

  task automatic testByteWrite();
    step(1'b1, 3'd1, 16'h5A5A, 1'b0, 3'd0, 3'd0);
    step(1'b1, 3'd1, 16'hEE3C, 1'b1, 3'd0, 3'd0);
    step(1'b1, 3'd6, 16'h1147, 1'b1, 3'd0, 3'd0);
    idle();
    step(1'b0, 3'd0, 16'h0, 1'b0, 3'd1, 3'd2);
    check("R6 low write", rdDataA, 16'h5A3C);
    check("R7 high write", rdDataB, expRead(3'd2, 1'b0));
    check("R7 high write value", rdDataB[15:8], 16'h0047);
  endtask

  task automatic testForward();
    step(1'b1, 3'd4, 16'hBEEF, 1'b0, 3'd4, 3'd5);
    check("R9 word forward", rdDataA, 16'hBEEF);
    check("R9 other port", rdDataB, expRead(3'd5, 1'b0));
    step(1'b1, 3'd7, 16'h00D2, 1'b1, 3'd3, 3'd7);
    check("R9 byte forward", rdDataB, 16'h00D2);
    check("R11 shared width", rdDataA, expRead(3'd3, 1'b1));
    step(1'b1, 3'd3, 16'h0019, 1'b1, 3'd3, 3'd7);
    check("R9 low forward", rdDataA, 16'h0019);
    idle();
    step(1'b0, 3'd0, 16'h0, 1'b0, 3'd3, 3'd4);
    check("R11 merged word", rdDataA, 16'hD219);
    check("R9 held", rdDataB, 16'hBEEF);
  endtask

  task automatic testLatency();
    step(1'b0, 3'd0, 16'h0, 1'b0, 3'd1, 3'd1);
    @(negedge clk); rdSelA = 3'd4; byteMode = 1'b0; #1;
    check("R8 before edge", rdDataA, expRead(3'd1, 1'b0));
    @(posedge clk); #1;
    check("R8 after edge", rdDataA, expRead(3'd4, 1'b0));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 initial A", rdDataA, 16'h0);
    check("R10 initial B", rdDataB, 16'h0);
    @(negedge clk); rst = 1'b0;
    testWordWrite();
    testIgnoredWrite();
    testByteRead();
    testByteWrite();
    testForward();
    testLatency();
    testWordWrite();
    testReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule